// File: doc/BRIEF.md
# Selectable Write-Through / Posted Write Path

This block routes cache write hits from a processor-side write port to a DRAM-side write port. It has two modes, and one configuration bit picks between them at run time. In write-through mode the processor write goes straight to the DRAM port in the same cycle. The processor is acknowledged only in the cycle the DRAM side reports the write as done. In posted mode the write is captured in a small in-order buffer and acknowledged at once. The buffer then empties to DRAM in the background, one entry at a time.

A read may only proceed while no buffered write is pending to the same address. This keeps reads coherent with the newest data. When the mode bit is cleared while writes are still buffered, the block finishes draining them before it accepts any write-through traffic. Tag lookup, DRAM timing and cache SRAM control are outside this block.

Top module: `wpb_top`

## Requirements
- R1: After reset the mode register reads 0x00 (write-through), no DRAM write is requested while the processor is idle, and a read is acknowledged in the cycle it is requested.
- R2: In write-through mode a processor write drives `mem_wr_req` with the same address, data and byte enables in the same cycle. `cpu_wr_ack` rises only in a cycle where `mem_done` is high.
- R3: The mode register sits at configuration address 4 and stores all 8 written bits, which read back on `cfg_rdata`. Reads of any other configuration address return 0x00.
- R4: Bit 7 of the mode register set to 1 selects posted mode. In that mode a write to a non-full buffer is acknowledged in the cycle it is requested, without waiting for `mem_done`.
- R5: Buffered writes reach the DRAM port in the order they were accepted, one request per write, with address, data and byte enables unchanged. The request at the head of the buffer is held until `mem_done`.
- R6: With 4 writes pending, a new processor write is not acknowledged until an entry has drained.
- R7: A read whose address equals that of any pending buffered write is not acknowledged until that write has drained. A read to any other address is acknowledged in the cycle it is requested.
- R8: After bit 7 is cleared with writes pending, the pending writes still drain in order. A new processor write is not acknowledged until the buffer is empty, and is then handled as a write-through write.
- R9: In write-through mode, with nothing buffered, a read is acknowledged in the cycle it is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| cpu_wr_req | input | 1 | Processor write request, held until acknowledged |
| cpu_rd_req | input | 1 | Processor read request, held until acknowledged |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_be | input | DW/8 | Processor byte enables |
| cpu_wr_ack | output | 1 | Write accepted or completed in this cycle |
| cpu_rd_ack | output | 1 | Read may proceed in this cycle |
| mem_wr_req | output | 1 | DRAM write request |
| mem_addr | output | AW | DRAM write address |
| mem_wdata | output | DW | DRAM write data |
| mem_be | output | DW/8 | DRAM byte enables |
| mem_done | input | 1 | DRAM write finished in this cycle |

## Verification
The hardest case to reach from the ports is clearing the mode bit while the buffer still holds writes. The processor must then see a write stall, neither posted nor passed through, while the head of the buffer keeps the DRAM port. The bench gets there by turning off its DRAM responder, so posted writes pile up. It then clears the mode bit and offers a new write. Only after several stalled cycles does it let the responder run, and it checks the order in which the writes reach memory. The same gating of the responder fills the buffer to its limit and holds a matching read pending.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  localparam int unsigned CFG_AW        = 4;
  localparam int unsigned CFG_MODE_ADDR = 4;
  localparam int unsigned POSTED_BIT    = 7;
  typedef logic [7:0] cfg_byte_t;
endpackage

// File: rtl/wpb_cfg_reg.sv
module wpb_cfg_reg
  import wpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  cfg_byte_t         wdata,
  output cfg_byte_t         rdata,
  output logic              posted_en
);
  logic      hit;
  logic      ld;
  cfg_byte_t mode_q;

  assign hit = (addr == CFG_AW'(CFG_MODE_ADDR));
  assign ld  = we && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (ld) mode_q <= wdata;
  end

  assign rdata     = hit ? mode_q : '0;
  assign posted_en = mode_q[POSTED_BIT];

  // R3: a stored write is visible on the next read of the same address
  a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (mode_q == $past(wdata)));
endmodule

// File: rtl/wpb_post_fifo.sv
module wpb_post_fifo #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [AW-1:0]      in_addr,
  input  logic [DW-1:0]      in_data,
  input  logic [DW/8-1:0]    in_be,
  output logic [AW-1:0]      head_addr,
  output logic [DW-1:0]      head_data,
  output logic [DW/8-1:0]    head_be,
  output logic               empty,
  output logic               full,
  input  logic [AW-1:0]      look_addr,
  output logic               look_hit
);
  localparam int unsigned BW = DW / 8;
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [BW-1:0]    ent_be   [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_n, match;
  logic [PW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]    cnt_q, cnt_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  always_comb begin
    wr_n  = push ? bump(wr_q) : wr_q;
    rd_n  = pop  ? bump(rd_q) : rd_q;
    cnt_n = cnt_q;
    vld_n = vld_q;
    if (push) begin
      cnt_n = cnt_n + 1'b1;
      vld_n[wr_q] = 1'b1;
    end
    if (pop) begin
      cnt_n = cnt_n - 1'b1;
      vld_n[rd_q] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      vld_q <= vld_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ld;
    assign ld = push && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (ld) begin
        ent_addr[i] <= in_addr;
        ent_data[i] <= in_data;
        ent_be[i]   <= in_be;
      end
    end
    assign match[i] = vld_q[i] && (ent_addr[i] == look_addr);
  end

  assign look_hit  = |match;
  assign head_addr = ent_addr[rd_q];
  assign head_data = ent_data[rd_q];
  assign head_be   = ent_be[rd_q];

  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r5_count_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> ($stable(head_addr) && $stable(head_data) && $stable(head_be)));
endmodule

// File: rtl/wpb_route.sv
module wpb_route #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               posted_en,
  input  logic               cpu_wr_req,
  input  logic               cpu_rd_req,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [DW/8-1:0]    cpu_be,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic               fifo_hit,
  input  logic [AW-1:0]      head_addr,
  input  logic [DW-1:0]      head_data,
  input  logic [DW/8-1:0]    head_be,
  input  logic               mem_done,
  output logic               push,
  output logic               pop,
  output logic               cpu_wr_ack,
  output logic               cpu_rd_ack,
  output logic               mem_wr_req,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic [DW/8-1:0]    mem_be
);
  logic wt_go;

  assign wt_go      = !posted_en && fifo_empty;
  assign push       = posted_en && cpu_wr_req && !fifo_full;
  assign pop        = !fifo_empty && mem_done;
  assign mem_wr_req = !fifo_empty || (wt_go && cpu_wr_req);
  assign mem_addr   = fifo_empty ? cpu_addr  : head_addr;
  assign mem_wdata  = fifo_empty ? cpu_wdata : head_data;
  assign mem_be     = fifo_empty ? cpu_be    : head_be;
  assign cpu_wr_ack = push || (wt_go && cpu_wr_req && mem_done);
  assign cpu_rd_ack = cpu_rd_req && !fifo_hit;

  // R2: a write-through completion coincides with the DRAM completion of that write
  a_r2_wt_ack_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_ack && !posted_en) |-> (mem_done && mem_wr_req && (mem_addr == cpu_addr)));
  // R4: a posted acceptance lands in the buffer
  a_r4_posted_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_ack && posted_en) |=> !fifo_empty);
endmodule

// File: rtl/wpb_top.sv
module wpb_top
  import wpb_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              cpu_wr_req,
  input  logic              cpu_rd_req,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [DW/8-1:0]   cpu_be,
  output logic              cpu_wr_ack,
  output logic              cpu_rd_ack,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [DW/8-1:0]   mem_be,
  input  logic              mem_done
);
  localparam int unsigned BW = DW / 8;

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          posted_en;
  logic          push, pop, f_empty, f_full, f_hit;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic [BW-1:0] h_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  wpb_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_sn), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .posted_en(posted_en)
  );

  wpb_post_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sn), .push(push), .pop(pop),
    .in_addr(cpu_addr), .in_data(cpu_wdata), .in_be(cpu_be),
    .head_addr(h_addr), .head_data(h_data), .head_be(h_be),
    .empty(f_empty), .full(f_full), .look_addr(cpu_addr), .look_hit(f_hit)
  );

  wpb_route #(.AW(AW), .DW(DW)) u_route (
    .clk(clk), .rst_n(rst_sn), .posted_en(posted_en),
    .cpu_wr_req(cpu_wr_req), .cpu_rd_req(cpu_rd_req), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .fifo_empty(f_empty), .fifo_full(f_full), .fifo_hit(f_hit),
    .head_addr(h_addr), .head_data(h_data), .head_be(h_be),
    .mem_done(mem_done), .push(push), .pop(pop),
    .cpu_wr_ack(cpu_wr_ack), .cpu_rd_ack(cpu_rd_ack),
    .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  // R8: while buffered writes remain outside posted mode, no write is acknowledged
  a_r8_drain_before_wt: assert property (@(posedge clk) disable iff (!rst_sn)
    (!posted_en && !f_empty) |-> !cpu_wr_ack);
  // R7: a read never proceeds past the write currently at the buffer head
  a_r7_rd_not_head: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_rd_ack && !f_empty) |-> (h_addr != cpu_addr));
  // R5: the DRAM port shows the buffer head whenever the buffer is occupied
  a_r5_head_on_port: assert property (@(posedge clk) disable iff (!rst_sn)
    !f_empty |-> (mem_wr_req && (mem_addr == h_addr)));
endmodule

// File: tb/wpb_top_tb.sv
`timescale 1ns/1ps
module wpb_top_tb;
  localparam int LAT = 2;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        cpu_wr_req, cpu_rd_req, cpu_wr_ack, cpu_rd_ack;
  logic [31:0] cpu_addr, cpu_wdata, mem_addr, mem_wdata;
  logic [3:0]  cpu_be, mem_be;
  logic        mem_wr_req, mem_done;

  int n_chk, n_fail;
  int resp_en, rcnt, n_log;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_be   [64];

  wpb_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_wr_req(cpu_wr_req), .cpu_rd_req(cpu_rd_req), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_wr_ack(cpu_wr_ack),
    .cpu_rd_ack(cpu_rd_ack), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_done(mem_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // DRAM model: completes each request LAT cycles after it appears
  always @(posedge clk) begin
    #2;
    if (mem_done) begin
      mem_done = 1'b0;
      rcnt = 0;
    end else if (resp_en != 0 && mem_wr_req) begin
      rcnt++;
      if (rcnt == LAT) begin
        if (n_log < 64) begin
          log_addr[n_log] = mem_addr;
          log_data[n_log] = mem_wdata;
          log_be[n_log]   = mem_be;
        end
        n_log++;
        mem_done = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] b, output int cyc);
    @(negedge clk);
    cpu_wr_req = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = b;
    cyc = 0;
    forever begin
      #1;
      if (cpu_wr_ack || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    @(posedge clk);
    #1 cpu_wr_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (!mem_wr_req && !mem_done) break;
    end
  endtask

  task automatic chk_log(input int idx, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] b, input string req);
    chk(log_addr[idx] == a, req, "drain address", log_addr[idx], a);
    chk(log_data[idx] == d, req, "drain data", log_data[idx], d);
    chk(log_be[idx] == b, req, "drain byte enables", log_be[idx], b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    cfg_addr = 4'd4; cpu_rd_req = 1'b1; cpu_addr = 32'h100;
    #1;
    chk(cfg_rdata == 8'h00, "R1", "mode register after reset", cfg_rdata, 8'h00);
    chk(mem_wr_req == 1'b0, "R1", "idle DRAM request", mem_wr_req, 0);
    chk(cpu_rd_ack == 1'b1, "R1", "read ack after reset", cpu_rd_ack, 1);
    @(negedge clk);
    cpu_rd_req = 1'b0;
  endtask

  task automatic t_cfg();
    cfg_write(4'd4, 8'h5A);
    cfg_addr = 4'd4; #1;
    chk(cfg_rdata == 8'h5A, "R3", "readback at address 4", cfg_rdata, 8'h5A);
    cfg_addr = 4'd3; #1;
    chk(cfg_rdata == 8'h00, "R3", "other address reads zero", cfg_rdata, 8'h00);
    cfg_write(4'd4, 8'h00);
    cfg_addr = 4'd4; #1;
    chk(cfg_rdata == 8'h00, "R3", "readback after clear", cfg_rdata, 8'h00);
  endtask

  task automatic t_write_through();
    int base, cyc;
    base = n_log; resp_en = 1;
    @(negedge clk);
    cpu_wr_req = 1'b1; cpu_addr = 32'h0000_0040; cpu_wdata = 32'hCAFE_0001; cpu_be = 4'h3;
    #1;
    chk(mem_wr_req == 1'b1, "R2", "same-cycle DRAM request", mem_wr_req, 1);
    chk(mem_addr == 32'h40, "R2", "pass-through address", mem_addr, 32'h40);
    chk(mem_wdata == 32'hCAFE_0001, "R2", "pass-through data", mem_wdata, 32'hCAFE_0001);
    chk(mem_be == 4'h3, "R2", "pass-through byte enables", mem_be, 4'h3);
    chk(cpu_wr_ack == 1'b0, "R2", "no early ack", cpu_wr_ack, 0);
    cyc = 0;
    forever begin
      #1;
      if (cpu_wr_ack || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == LAT, "R2", "ack cycle equals DRAM latency", cyc, LAT);
    chk(mem_done == 1'b1, "R2", "ack with DRAM done", mem_done, 1);
    @(posedge clk);
    #1 cpu_wr_req = 1'b0;
    wait_idle();
    chk(n_log - base == 1, "R2", "one DRAM write", n_log - base, 1);
    @(negedge clk);
    cpu_rd_req = 1'b1; cpu_addr = 32'h40; #1;
    chk(cpu_rd_ack == 1'b1, "R9", "read ack in write-through", cpu_rd_ack, 1);
    @(negedge clk);
    cpu_rd_req = 1'b0;
  endtask

  task automatic t_posted_fill();
    int base, cyc;
    cfg_write(4'd4, 8'h80);
    resp_en = 0; base = n_log;
    for (int i = 0; i < 4; i++) begin
      cpu_write(32'h1000 + 32'(i) * 4, 32'hA000_0000 + 32'(i), 4'(i + 1), cyc);
      chk(cyc == 0, "R4", "posted ack in request cycle", cyc, 0);
    end
    #1;
    chk(n_log - base == 0, "R4", "no DRAM completion needed", n_log - base, 0);
    chk(mem_addr == 32'h1000, "R5", "oldest entry at port", mem_addr, 32'h1000);
    @(negedge clk);
    cpu_wr_req = 1'b1; cpu_addr = 32'h1010; cpu_wdata = 32'hA000_0004; cpu_be = 4'hF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(cpu_wr_ack == 1'b0, "R6", "stall while buffer full", cpu_wr_ack, 0);
      @(negedge clk);
    end
    resp_en = 1; cyc = 0;
    forever begin
      #1;
      if (cpu_wr_ack || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    chk(cpu_wr_ack == 1'b1, "R6", "accepted after a drain", cpu_wr_ack, 1);
    chk(n_log - base == 1, "R6", "exactly one entry drained first", n_log - base, 1);
    @(posedge clk);
    #1 cpu_wr_req = 1'b0;
    wait_idle();
    chk(n_log - base == 5, "R5", "five DRAM writes", n_log - base, 5);
    for (int i = 0; i < 4; i++)
      chk_log(base + i, 32'h1000 + 32'(i) * 4, 32'hA000_0000 + 32'(i), 4'(i + 1), "R5");
    chk_log(base + 4, 32'h1010, 32'hA000_0004, 4'hF, "R5");
  endtask

  task automatic t_read_hold();
    int base, cyc;
    resp_en = 0; base = n_log;
    cpu_write(32'h2000, 32'hB000_0000, 4'hF, cyc);
    cpu_write(32'h2004, 32'hB000_0001, 4'hF, cyc);
    @(negedge clk);
    cpu_rd_req = 1'b1; cpu_addr = 32'h2004; #1;
    chk(cpu_rd_ack == 1'b0, "R7", "read held on pending address", cpu_rd_ack, 0);
    cpu_addr = 32'h2008; #1;
    chk(cpu_rd_ack == 1'b1, "R7", "read to other address proceeds", cpu_rd_ack, 1);
    cpu_addr = 32'h2004;
    @(negedge clk);
    resp_en = 1; cyc = 0;
    forever begin
      #1;
      if (cpu_rd_ack || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    chk(n_log - base == 2, "R7", "read released after its write drained", n_log - base, 2);
    @(negedge clk);
    cpu_rd_req = 1'b0;
    wait_idle();
  endtask

  task automatic t_mode_drop();
    int base, cyc;
    resp_en = 0; base = n_log;
    cpu_write(32'h3000, 32'hC000_0000, 4'h1, cyc);
    cpu_write(32'h3004, 32'hC000_0001, 4'h2, cyc);
    cfg_write(4'd4, 8'h00);
    cpu_wr_req = 1'b1; cpu_addr = 32'h3008; cpu_wdata = 32'hC000_0002; cpu_be = 4'h4;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(cpu_wr_ack == 1'b0, "R8", "write stalled while draining", cpu_wr_ack, 0);
      chk(mem_addr == 32'h3000, "R8", "buffer head keeps the port", mem_addr, 32'h3000);
      @(negedge clk);
    end
    resp_en = 1; cyc = 0;
    forever begin
      #1;
      if (cpu_wr_ack || cyc > 60) break;
      @(negedge clk);
      cyc++;
    end
    chk(mem_done == 1'b1, "R8", "write-through ack with DRAM done", mem_done, 1);
    chk(n_log - base == 3, "R8", "drained then written through", n_log - base, 3);
    @(posedge clk);
    #1 cpu_wr_req = 1'b0;
    wait_idle();
    chk_log(base + 0, 32'h3000, 32'hC000_0000, 4'h1, "R8");
    chk_log(base + 1, 32'h3004, 32'hC000_0001, 4'h2, "R8");
    chk_log(base + 2, 32'h3008, 32'hC000_0002, 4'h4, "R8");
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; resp_en = 0; rcnt = 0; n_log = 0;
    mem_done = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cpu_wr_req = 1'b0; cpu_rd_req = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_write_through();
    t_posted_fill();
    t_read_hold();
    t_mode_drop();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule